// File: doc/BRIEF.md
# Two-Dimensional One-Hot Grid Scanner

This block walks a rectangular grid of sensing elements, 14 columns by 10 rows by default, and selects exactly one element in every clock cycle. Two circular one-hot pointers produce the selection. The column pointer moves on every clock. The row pointer moves only when the column pointer leaves its last column and returns to column 0. One full pass therefore covers all 140 elements in 140 clocks. At a 2 MHz clock that is roughly 14,290 passes per second.

Next to the select buses, the block reports two values. The first is the binary number of the selected element, equal to row × columns + column. The second is a strobe that is high in the cycle in which element 0 is selected. From the same single clock, the block also produces two phase enables that are never high together. They are meant for downstream pseudo-static latches, which need non-overlapping phases. A synchronous reset puts everything into a fixed start state, so the scan order after reset is always the same.

Top module: `grid_scanner`

## Requirements
- R1: While reset is high at a clock edge, the block afterwards shows column 0 and row 0 selected (bit 0 of each select bus high, all other bits low), element number 0, the start strobe high, and both phase enables low.
- R2: Each clock edge with reset low moves the column selection from bit c to bit c+1. From the last column (bit 13 by default) it moves back to bit 0.
- R3: The row selection moves from bit r to bit r+1, wrapping from the last row back to bit 0, only on an edge at which the column selection goes from the last column to column 0. At every other edge it holds its value.
- R4: Exactly one bit of the column select bus and exactly one bit of the row select bus are high in every cycle.
- R5: The element number output equals row × COLS + column, where row and column are the bit positions that are high on the select buses.
- R6: The start strobe is high exactly in the cycles in which element 0 is selected. Without reset, this happens once every COLS × ROWS clocks.
- R7: The two phase enables are never high in the same cycle. Between a cycle with one enable high and the next cycle with the other enable high, there are at least DEAD_CYC cycles (default 1) in which both are low.
- R8: Counting the edges after reset is released as n = 1, 2, and so on, phase 1 is high when (n−1) mod P equals 0, and phase 2 is high when (n−1) mod P equals 1 + DEAD_CYC. Here P = 2 + 2·DEAD_CYC.
- R9: A reset applied in the middle of a pass restarts both the scan and the phase sequence from the R1 state, and scanning resumes at element 1 on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for pointers and phase generation |
| rst | input | 1 | Synchronous reset, active high |
| col_sel | output | COLS (14) | One-hot column select |
| row_sel | output | ROWS (10) | One-hot row select |
| elem_idx | output | clog2(COLS·ROWS) (8) | Binary number of the selected element |
| scan_start | output | 1 | High while element 0 is selected |
| ph1_en | output | 1 | First non-overlapping phase enable |
| ph2_en | output | 1 | Second non-overlapping phase enable |

## Verification
Every output comes straight from a register with one stage of latency. The value produced by clock edge n after reset release is therefore visible in the cycle that follows that edge. The bench keeps its own count of edges since the last reset release and derives the expected column, row, element number, strobe and phases from that count alone. It samples on the falling edge, half a period after the rising edge that updated the registers. Reset is also changed only on falling edges, so each check sees settled values and never depends on the order of events at the rising edge.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // Phase sequencer states, cycled in this order
    typedef enum logic [1:0] {
        PH_A    = 2'd0,
        GAP_AB  = 2'd1,
        PH_B    = 2'd2,
        GAP_BA  = 2'd3
    } phase_e;

    localparam int GAP_CNT_W = 8;

    typedef struct packed {
        phase_e                 st;
        logic [GAP_CNT_W-1:0]   gap_cnt;
    } phase_state_t;

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [N-1:0] ptr,
    output logic         at_last
);

    logic [N-1:0] ptr_d, ptr_q;

    generate
        if (N == 1) begin : g_single
            always_comb ptr_d = ptr_q;
        end else begin : g_multi
            always_comb begin
                ptr_d = ptr_q;
                if (step) ptr_d = {ptr_q[N-2:0], ptr_q[N-1]};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= {{(N-1){1'b0}}, 1'b1};
        else     ptr_q <= ptr_d;
    end

    assign ptr     = ptr_q;
    assign at_last = ptr_q[N-1];

    // R4: pointer stays one-hot
    assert_ptr_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(ptr_q) == 1);

    // R3: no step request means the pointer holds
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(ptr_q));

endmodule

// File: rtl/scan_index.sv
module scan_index #(
    parameter int COLS = 14,
    parameter int ROWS = 10
) (
    input  logic                               clk,
    input  logic                               rst,
    output logic [$clog2(COLS*ROWS)-1:0]       elem_idx,
    output logic                               scan_start
);

    localparam int TOTAL = COLS * ROWS;
    localparam int IW    = $clog2(TOTAL);
    localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic [IW-1:0] idx;
        logic          start;
    } idx_state_t;

    idx_state_t s_d, s_q;
    logic       col_wrap;

    always_comb begin
        s_d      = s_q;
        col_wrap = (s_q.col == CW'(COLS - 1));
        s_d.col  = col_wrap ? '0 : s_q.col + CW'(1);
        if (col_wrap)
            s_d.row = (s_q.row == RW'(ROWS - 1)) ? '0 : s_q.row + RW'(1);
        s_d.idx   = (s_q.idx == IW'(TOTAL - 1)) ? '0 : s_q.idx + IW'(1);
        s_d.start = (s_d.idx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.col   <= '0;
            s_q.row   <= '0;
            s_q.idx   <= '0;
            s_q.start <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign elem_idx   = s_q.idx;
    assign scan_start = s_q.start;

    // R5: flat count agrees with separate row/column counters
    assert_idx_split_R5: assert property (@(posedge clk) disable iff (rst)
        32'(s_q.idx) == 32'(s_q.row) * COLS + 32'(s_q.col));

    // R6: strobe only at element 0
    assert_start_zero_R6: assert property (@(posedge clk) disable iff (rst)
        s_q.start == (s_q.idx == '0));

endmodule

// File: rtl/phase_gen.sv
module phase_gen
    import scan_pkg::*;
#(
    parameter int DEAD_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    output logic ph1_en,
    output logic ph2_en
);

    localparam logic [GAP_CNT_W-1:0] GAP_LAST = GAP_CNT_W'(DEAD_CYC - 1);

    phase_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            PH_A: begin
                s_d.st      = GAP_AB;
                s_d.gap_cnt = '0;
            end
            GAP_AB: begin
                if (s_q.gap_cnt == GAP_LAST) s_d.st = PH_B;
                else s_d.gap_cnt = s_q.gap_cnt + 1'b1;
            end
            PH_B: begin
                s_d.st      = GAP_BA;
                s_d.gap_cnt = '0;
            end
            GAP_BA: begin
                if (s_q.gap_cnt == GAP_LAST) s_d.st = PH_A;
                else s_d.gap_cnt = s_q.gap_cnt + 1'b1;
            end
            default: s_d.st = GAP_BA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st      <= GAP_BA;
            s_q.gap_cnt <= GAP_LAST;
        end else begin
            s_q <= s_d;
        end
    end

    assign ph1_en = (s_q.st == PH_A);
    assign ph2_en = (s_q.st == PH_B);

    // R7: phases never overlap
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(ph1_en && ph2_en));

    // R7: a phase is always followed by a low cycle of both
    assert_dead_after_ph1_R7: assert property (@(posedge clk) disable iff (rst)
        ph1_en |=> (!ph1_en && !ph2_en));

    assert_dead_after_ph2_R7: assert property (@(posedge clk) disable iff (rst)
        ph2_en |=> (!ph1_en && !ph2_en));

endmodule

// File: rtl/grid_scanner.sv
module grid_scanner #(
    parameter int COLS     = 14,
    parameter int ROWS     = 10,
    parameter int DEAD_CYC = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    output logic [COLS-1:0]              col_sel,
    output logic [ROWS-1:0]              row_sel,
    output logic [$clog2(COLS*ROWS)-1:0] elem_idx,
    output logic                         scan_start,
    output logic                         ph1_en,
    output logic                         ph2_en
);

    logic col_last;
    logic row_last;

    ring_ptr #(.N(COLS)) u_col (
        .clk     (clk),
        .rst     (rst),
        .step    (1'b1),
        .ptr     (col_sel),
        .at_last (col_last)
    );

    ring_ptr #(.N(ROWS)) u_row (
        .clk     (clk),
        .rst     (rst),
        .step    (col_last),
        .ptr     (row_sel),
        .at_last (row_last)
    );

    scan_index #(.COLS(COLS), .ROWS(ROWS)) u_idx (
        .clk        (clk),
        .rst        (rst),
        .elem_idx   (elem_idx),
        .scan_start (scan_start)
    );

    phase_gen #(.DEAD_CYC(DEAD_CYC)) u_ph (
        .clk    (clk),
        .rst    (rst),
        .ph1_en (ph1_en),
        .ph2_en (ph2_en)
    );

    // R6: strobe coincides with the one-hot origin of both pointers
    assert_start_origin_R6: assert property (@(posedge clk) disable iff (rst)
        scan_start |-> (col_sel[0] && row_sel[0]));

    // R2: last column is followed by column 0
    assert_col_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        col_sel[COLS-1] |=> col_sel[0]);

    // R3: full-grid wrap returns the row pointer to row 0
    assert_row_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (col_last && row_last) |=> (row_sel[0] && scan_start));

    // R5: column bit agrees with the flat element number
    assert_idx_col_R5: assert property (@(posedge clk) disable iff (rst)
        col_sel[32'(elem_idx) % COLS]);

endmodule

// File: tb/tb_grid_scanner.sv
module tb_grid_scanner;

    localparam int COLS  = 14;
    localparam int ROWS  = 10;
    localparam int DEAD  = 1;
    localparam int TOTAL = COLS * ROWS;
    localparam int PER   = 2 + 2 * DEAD;
    localparam int IW    = $clog2(TOTAL);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [COLS-1:0] col_sel;
    logic [ROWS-1:0] row_sel;
    logic [IW-1:0]   elem_idx;
    logic            scan_start, ph1_en, ph2_en;

    int checks = 0;
    int errors = 0;
    int n      = 0;   // edges since reset release
    bit done   = 1'b0;

    always #5 clk = ~clk;

    grid_scanner #(.COLS(COLS), .ROWS(ROWS), .DEAD_CYC(DEAD)) dut (
        .clk(clk), .rst(rst), .col_sel(col_sel), .row_sel(row_sel),
        .elem_idx(elem_idx), .scan_start(scan_start),
        .ph1_en(ph1_en), .ph2_en(ph2_en)
    );

    function automatic int exp_elem(int edges);
        return edges % TOTAL;
    endfunction
    function automatic logic [COLS-1:0] exp_col(int edges);
        return COLS'(1) << (exp_elem(edges) % COLS);
    endfunction
    function automatic logic [ROWS-1:0] exp_row(int edges);
        return ROWS'(1) << (exp_elem(edges) / COLS);
    endfunction
    function automatic logic exp_ph1(int edges);
        return (edges > 0) && (((edges - 1) % PER) == 0);
    endfunction
    function automatic logic exp_ph2(int edges);
        return (edges > 0) && (((edges - 1) % PER) == 1 + DEAD);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %0h expected %0h", req, n, act, exp);
        end
    endtask

    task automatic check_all(string tag_pos, string tag_row);
        check(tag_pos, col_sel, exp_col(n));
        check(tag_row, row_sel, exp_row(n));
        check("R4", $countones(col_sel) + $countones(row_sel), 2);
        check("R5", elem_idx, exp_elem(n));
        check("R6", scan_start, exp_elem(n) == 0);
        check("R7", ph1_en & ph2_en, 0);
        check("R8", {ph1_en, ph2_en}, {exp_ph1(n), exp_ph2(n)});
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            n++;
            check_all("R2", "R3");
        end
    endtask

    task automatic do_reset(int cycles, string req);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) @(negedge clk);
        n = 0;
        check_all(req, req);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset(2, "R1");
        // R2/R3/R6: two full passes, including both wraps
        run(2 * TOTAL + 3);
        // R9: reset at the last element of a pass
        run(TOTAL - 3 - 1);
        check("R9", elem_idx, TOTAL - 1);
        do_reset(1, "R9");
        run(1);
        check("R9", elem_idx, 1);
        // random segments mixed with random resets
        for (int seg = 0; seg < 40; seg++) begin
            run($urandom_range(1, 300));
            if ($urandom_range(0, 3) == 0) do_reset($urandom_range(1, 3), "R9");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule